// File: doc/BRIEF.md
# Three-Level Pin Function Selector

This block chooses, for every pin of a bank, which peripheral function drives it. Each pin has a 4-bit primary code and a 6-bit secondary code. A primary code below ten selects a peripheral directly. The primary value 15 hands the choice to the secondary code. The block reduces both codes to one flat function index per pin. It also produces a drive-enable, an error flag and a flag for the management-bus path.

Two of the secondary functions route the pin to the management bus: the main one and an alternate one. Two management channels each carry a 3-bit source choice. Source 0 leaves the channel floating, and sources 1 to 7 pick an internal peripheral. All outputs are registered, so pad logic downstream sees clean values that change exactly one edge after the selects.

Top module: `pin_func_mux`

## Requirements
- R1: While rst_n is low, every output is zero: indices, enables, error flags, management flags, channel sources and channel output-enables.
- R2: A primary code from 0 to 9 makes the pin's index equal that code, with enable 1 and error 0.
- R3: A primary code of 15 with a secondary code from 0 to 61 makes the pin's index 10 plus the secondary code, with enable 1 and error 0.
- R4: A primary code from 10 to 14 is invalid: index 0, enable 0, error 1, management flag 0.
- R5: A primary code of 15 with a secondary code of 62 or 63 is invalid: index 0, enable 0, error 1, management flag 0.
- R6: A pin's management flag is 1 exactly when its primary code is 15 and its secondary code is 8 (main) or 9 (alternate). In every other case the flag is 0, including a primary code of 8 or 9.
- R7: Each channel's source output repeats its 3-bit source input. Its output-enable is 0 for source 0 and 1 for sources 1 to 7.
- R8: Every output changes only at the clock edge after its input changes, exactly one edge later. Each pin's outputs depend only on that pin's own codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| l1_code_i | input | NUM_PINS*4 | Primary code per pin, pin p at bits [4p+3:4p] |
| l2_code_i | input | NUM_PINS*6 | Secondary code per pin, pin p at bits [6p+5:6p] |
| mgmt_src_i | input | NUM_MGMT*3 | Source choice per management channel |
| pin_fidx_o | output | NUM_PINS*7 | Flat function index per pin |
| pin_en_o | output | NUM_PINS | Pin is driven by a valid function |
| pin_err_o | output | NUM_PINS | Pin code is invalid |
| pin_mgmt_o | output | NUM_PINS | Pin routed to the management-bus path |
| mgmt_src_o | output | NUM_MGMT*3 | Registered channel source |
| mgmt_oe_o | output | NUM_MGMT | Channel output-enable, low when floating |

## Verification
Every pin and channel result is due exactly one rising edge after its input changes. The bench drives inputs on a falling edge and checks them on the next falling edge, after that single register. One scenario also samples just after the drive, before the rising edge, to confirm the old value still holds. The boundary codes 9, 10, 14, 15, 61, 62 and 63 are each checked at that same one-edge offset.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
   typedef enum logic [1:0] {
      K_DIRECT = 2'd0,
      K_DEFER  = 2'd1,
      K_BAD    = 2'd2
   } code_kind_e;
endpackage

// File: rtl/pfm_pin_decode.sv
module pfm_pin_decode #(
   parameter int L1_W      = 4,
   parameter int L2_W      = 6,
   parameter int FIDX_W    = 7,
   parameter int L1_DIRECT = 10,
   parameter int L1_DEFER  = 15,
   parameter int L2_MAX    = 61,
   parameter int MGMT_A    = 8,
   parameter int MGMT_B    = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [L1_W-1:0]   l1_i,
   input  logic [L2_W-1:0]   l2_i,
   output logic [FIDX_W-1:0] fidx_o,
   output logic              en_o,
   output logic              err_o,
   output logic              mgmt_o
);
   import pfm_pkg::*;

   localparam logic [L1_W-1:0]   DIR_LIM = L1_W'(L1_DIRECT);
   localparam logic [L1_W-1:0]   DEF_CODE = L1_W'(L1_DEFER);
   localparam logic [L2_W-1:0]   L2_LIM = L2_W'(L2_MAX);
   localparam logic [L2_W-1:0]   MG_A = L2_W'(MGMT_A);
   localparam logic [L2_W-1:0]   MG_B = L2_W'(MGMT_B);
   localparam logic [FIDX_W-1:0] L2_BASE = FIDX_W'(L1_DIRECT);

   code_kind_e        kind;
   logic [FIDX_W-1:0] nxt_fidx;
   logic              nxt_mgmt;

   always_comb begin
      if (l1_i < DIR_LIM)
         kind = K_DIRECT;
      else if (l1_i == DEF_CODE && l2_i <= L2_LIM)
         kind = K_DEFER;
      else
         kind = K_BAD;
   end

   always_comb begin
      nxt_fidx = '0;
      nxt_mgmt = 1'b0;
      unique case (kind)
         K_DIRECT: nxt_fidx = FIDX_W'(l1_i);
         K_DEFER: begin
            nxt_fidx = L2_BASE + FIDX_W'(l2_i);
            nxt_mgmt = (l2_i == MG_A) || (l2_i == MG_B);
         end
         default: nxt_fidx = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fidx_o <= '0;
         en_o   <= 1'b0;
         err_o  <= 1'b0;
         mgmt_o <= 1'b0;
      end else begin
         fidx_o <= nxt_fidx;
         en_o   <= (kind != K_BAD);
         err_o  <= (kind == K_BAD);
         mgmt_o <= nxt_mgmt;
      end
   end

   a_r2_direct_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (l1_i < DIR_LIM) |=> (en_o && !err_o && fidx_o == FIDX_W'($past(l1_i))));

   a_r3_defer_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (l1_i == DEF_CODE && l2_i <= L2_LIM) |=>
      (en_o && !err_o && fidx_o == L2_BASE + FIDX_W'($past(l2_i))));

   a_r5_bad_is_safe: assert property (@(posedge clk) disable iff (!rst_n)
      (l1_i >= DIR_LIM && !(l1_i == DEF_CODE && l2_i <= L2_LIM)) |=>
      (err_o && !en_o && !mgmt_o && fidx_o == '0));

   a_r6_mgmt_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      mgmt_o |-> (en_o && !err_o));
endmodule

// File: rtl/pfm_mgmt_chan.sv
module pfm_mgmt_chan #(
   parameter int SRC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] src_i,
   output logic [SRC_W-1:0] src_o,
   output logic             oe_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_o <= '0;
         oe_o  <= 1'b0;
      end else begin
         src_o <= src_i;
         oe_o  <= |src_i;
      end
   end

   a_r7_oe_tracks_src: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (oe_o == ($past(src_i) != '0) && src_o == $past(src_i)));

   a_r7_float_off: assert property (@(posedge clk) disable iff (!rst_n)
      (src_o == '0) |-> !oe_o);
endmodule

// File: rtl/pin_func_mux.sv
module pin_func_mux #(
   parameter int NUM_PINS  = 4,
   parameter int NUM_MGMT  = 2,
   parameter int L1_W      = 4,
   parameter int L2_W      = 6,
   parameter int SRC_W     = 3,
   parameter int L1_DIRECT = 10,
   parameter int L1_DEFER  = 15,
   parameter int L2_MAX    = 61,
   parameter int MGMT_A    = 8,
   parameter int MGMT_B    = 9,
   localparam int FIDX_W   = $clog2(L1_DIRECT + L2_MAX + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_PINS*L1_W-1:0]  l1_code_i,
   input  logic [NUM_PINS*L2_W-1:0]  l2_code_i,
   input  logic [NUM_MGMT*SRC_W-1:0] mgmt_src_i,
   output logic [NUM_PINS*FIDX_W-1:0] pin_fidx_o,
   output logic [NUM_PINS-1:0]       pin_en_o,
   output logic [NUM_PINS-1:0]       pin_err_o,
   output logic [NUM_PINS-1:0]       pin_mgmt_o,
   output logic [NUM_MGMT*SRC_W-1:0] mgmt_src_o,
   output logic [NUM_MGMT-1:0]       mgmt_oe_o
);
   if (L1_DEFER < L1_DIRECT || L1_DEFER >= (1 << L1_W)) begin : g_bad_defer
      $error("pin_func_mux: defer code outside primary code space");
   end
   if (L2_MAX >= (1 << L2_W)) begin : g_bad_l2
      $error("pin_func_mux: secondary limit exceeds code width");
   end
   if (MGMT_A > L2_MAX || MGMT_B > L2_MAX || MGMT_A == MGMT_B) begin : g_bad_mgmt
      $error("pin_func_mux: management functions misconfigured");
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      pfm_pin_decode #(
         .L1_W(L1_W), .L2_W(L2_W), .FIDX_W(FIDX_W),
         .L1_DIRECT(L1_DIRECT), .L1_DEFER(L1_DEFER), .L2_MAX(L2_MAX),
         .MGMT_A(MGMT_A), .MGMT_B(MGMT_B)
      ) u_dec (
         .clk    (clk),
         .rst_n  (rst_n),
         .l1_i   (l1_code_i[p*L1_W +: L1_W]),
         .l2_i   (l2_code_i[p*L2_W +: L2_W]),
         .fidx_o (pin_fidx_o[p*FIDX_W +: FIDX_W]),
         .en_o   (pin_en_o[p]),
         .err_o  (pin_err_o[p]),
         .mgmt_o (pin_mgmt_o[p])
      );
   end

   for (genvar c = 0; c < NUM_MGMT; c++) begin : g_chan
      pfm_mgmt_chan #(.SRC_W(SRC_W)) u_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .src_i (mgmt_src_i[c*SRC_W +: SRC_W]),
         .src_o (mgmt_src_o[c*SRC_W +: SRC_W]),
         .oe_o  (mgmt_oe_o[c])
      );
   end

   a_r4_err_excludes_en: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_err_o & pin_en_o) == '0);

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (pin_en_o == '0 && pin_err_o == '0 && mgmt_oe_o == '0));
endmodule

// File: tb/sim_pin_func_mux.sv
module sim_pin_func_mux;
   localparam int NP = 4;
   localparam int NM = 2;
   localparam int FW = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP*4-1:0]  l1 = '0;
   logic [NP*6-1:0]  l2 = '0;
   logic [NM*3-1:0]  src = '0;
   logic [NP*FW-1:0] fidx;
   logic [NP-1:0]    en, err, mg;
   logic [NM*3-1:0]  src_q;
   logic [NM-1:0]    oe;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   always #5 clk = ~clk;

   pin_func_mux u0 (
      .clk(clk), .rst_n(rst_n), .l1_code_i(l1), .l2_code_i(l2),
      .mgmt_src_i(src), .pin_fidx_o(fidx), .pin_en_o(en), .pin_err_o(err),
      .pin_mgmt_o(mg), .mgmt_src_o(src_q), .mgmt_oe_o(oe)
   );

   task automatic cmp(input string req, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // model built from R2..R6
   task automatic check_pin(input string req, input int p, input int c1, input int c2);
      int ef, ee, er, em;
      if (c1 < 10) begin ef = c1; ee = 1; er = 0; em = 0; end
      else if (c1 == 15 && c2 <= 61) begin
         ef = 10 + c2; ee = 1; er = 0; em = (c2 == 8 || c2 == 9) ? 1 : 0;
      end else begin ef = 0; ee = 0; er = 1; em = 0; end
      cmp({req, " fidx"}, int'(fidx[p*FW +: FW]), ef);
      cmp({req, " en"}, int'(en[p]), ee);
      cmp({req, " err"}, int'(err[p]), er);
      cmp({req, " mgmt"}, int'(mg[p]), em);
   endtask

   task automatic apply_all(input int c1, input int c2);
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
         l1[p*4 +: 4] = 4'(c1);
         l2[p*6 +: 6] = 6'(c2);
      end
      @(negedge clk);
      for (int p = 0; p < NP; p++) check_pin("code", p, c1, c2);
   endtask

   task automatic t_reset();
      cmp("R1 fidx", int'(fidx), 0);
      cmp("R1 en", int'(en), 0);
      cmp("R1 err", int'(err), 0);
      cmp("R1 mgmt", int'(mg), 0);
      cmp("R1 src", int'(src_q), 0);
      cmp("R1 oe", int'(oe), 0);
   endtask

   task automatic t_direct();
      int codes[3] = '{0, 5, 9};
      foreach (codes[i]) begin
         $display("R2 direct code %0d", codes[i]);
         apply_all(codes[i], 33);
      end
   endtask

   task automatic t_defer();
      int codes[4] = '{0, 18, 40, 61};
      foreach (codes[i]) begin
         $display("R3 deferred code %0d", codes[i]);
         apply_all(15, codes[i]);
      end
   endtask

   task automatic t_bad_l1();
      $display("R4 invalid primary 10, 14");
      apply_all(10, 0);
      apply_all(14, 8);
   endtask

   task automatic t_bad_l2();
      $display("R5 invalid secondary 62, 63");
      apply_all(15, 62);
      apply_all(15, 63);
   endtask

   task automatic t_mgmt();
      $display("R6 management main, alternate, neighbours");
      apply_all(15, 8);
      apply_all(15, 9);
      apply_all(15, 7);
      apply_all(8, 8);
   endtask

   task automatic t_chan();
      int vals[4] = '{0, 3, 7, 1};
      foreach (vals[i]) begin
         @(negedge clk);
         src = {3'(vals[(i + 1) % 4]), 3'(vals[i])};
         @(negedge clk);
         cmp("R7 src0", int'(src_q[2:0]), vals[i]);
         cmp("R7 src1", int'(src_q[5:3]), vals[(i + 1) % 4]);
         cmp("R7 oe0", int'(oe[0]), vals[i] != 0 ? 1 : 0);
         cmp("R7 oe1", int'(oe[1]), vals[(i + 1) % 4] != 0 ? 1 : 0);
      end
   endtask

   task automatic t_latency_indep();
      int c1[4] = '{3, 15, 12, 15};
      int c2[4] = '{0, 9, 5, 62};
      apply_all(2, 0);
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
         l1[p*4 +: 4] = 4'(c1[p]);
         l2[p*6 +: 6] = 6'(c2[p]);
      end
      #1;
      for (int p = 0; p < NP; p++) check_pin("R8 before edge", p, 2, 0);
      @(negedge clk);
      for (int p = 0; p < NP; p++) check_pin("R8 per pin", p, c1[p], c2[p]);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_direct();
      t_defer();
      t_bad_l1();
      t_bad_l2();
      t_mgmt();
      t_chan();
      t_latency_indep();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule